// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps the books for a shared packet buffer that is carved into fixed-size pages. It does not hold packet data itself. It records which page belongs to which packet and hands out small packet numbers. A host issues commands on a single command port: allocate room for a transmit packet, allocate room for a receive packet, or release the packet whose number sits in the packet-number register. An allocation succeeds in one cycle. It sets a done flag and returns the lowest packet number not in use. If there is not enough room, it sets a fail flag instead and nothing changes.

The host can hold a number of pages back for transmit traffic. A receive allocation may not dip into the part of that reservation that transmit packets are not already using, while transmit allocations may use any free page. When a transmit completes, the MAC reports the packet number and whether the send succeeded. With automatic release enabled, a successful packet's pages are freed at once. Any other completion is queued in a completion FIFO. A second FIFO queues the numbers of received packets. Both FIFOs hold as many entries as there are pages.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset all 18 pages are free (`free_pages` = 18), both FIFOs report empty, `alloc_done` and `alloc_fail` are 0, and `pnr_q` is 0.
- R2: An allocate command (`cmd_op` 1 = transmit, 2 = receive) for N bytes needs ceil(N/256) pages, or 1 page when N = 0. On success, one cycle later `alloc_done` = 1, `alloc_fail` = 0, `alloc_pkt` is the lowest packet number not owned by any page, and `free_pages` has dropped by the page count.
- R3: An allocate command that cannot be satisfied sets `alloc_fail` = 1 and `alloc_done` = 0 one cycle later, leaves `alloc_pkt` and the page table unchanged, and the same command succeeds once enough pages are free.
- R4: A release command (`cmd_op` 3) frees every page owned by the packet number in `pnr_q`. That number becomes available again.
- R5: Let T be the number of pages owned by transmit packets and R the value of `reserve_pages`. A receive allocation of P pages succeeds only if P + max(0, R − T) ≤ free pages. A transmit allocation ignores R, and R = 0 imposes no hold-back.
- R6: A transmit completion with `tx_done_ok` = 1 while `auto_release` = 1 frees that packet's pages and is not queued. Every other transmit completion is pushed into the transmit-completion FIFO.
- R7: Each FIFO returns packet numbers in arrival order. A push to a full FIFO is dropped and leaves its contents unchanged. A pop from an empty FIFO leaves it empty.
- R8: When an allocation and a release happen in the same cycle, the allocation is judged against the free count from before that cycle. Both then take effect, so `free_pages` afterwards equals the old count minus the granted pages plus the released pages.
- R9: `pnr_q` takes the value on `pnr_din` one cycle after `pnr_wr` and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 none, 1 allocate transmit, 2 allocate receive, 3 release |
| cmd_bytes | input | 13 | Requested packet size in bytes |
| pnr_wr | input | 1 | Write strobe for the packet-number register |
| pnr_din | input | 5 | Packet number to write |
| reserve_pages | input | 5 | Pages held back for transmit |
| auto_release | input | 1 | Free successful transmits automatically |
| tx_done_valid | input | 1 | Transmit completion strobe |
| tx_done_pkt | input | 5 | Packet number of the completed transmit |
| tx_done_ok | input | 1 | Transmit succeeded |
| rx_done_valid | input | 1 | Received-packet strobe |
| rx_done_pkt | input | 5 | Packet number of the received packet |
| rx_pop | input | 1 | Pop the receive FIFO |
| tx_pop | input | 1 | Pop the transmit-completion FIFO |
| pnr_q | output | 5 | Packet-number register |
| alloc_done | output | 1 | Last allocation succeeded |
| alloc_fail | output | 1 | Last allocation failed |
| alloc_pkt | output | 5 | Packet number granted by the last successful allocation |
| free_pages | output | 5 | Free pages |
| rx_head | output | 5 | Oldest receive FIFO entry |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_head | output | 5 | Oldest transmit-completion FIFO entry |
| tx_empty | output | 1 | Transmit-completion FIFO empty |

## Verification
An allocation command and an automatic release can arrive in the same cycle, because the command port and the MAC completion path are independent. The bench provokes this twice. In the first case, a 13-page transmit allocation against 13 free pages coincides with the automatic release of a 2-page packet. The allocation must succeed with a fresh packet number, and the free count must settle at 2. In the second case, a 3-page request against 2 free pages coincides with the release of a 1-page packet. The request must fail even though 3 pages are free afterwards, and the released packet must not appear in the completion FIFO.

// File: rtl/pga_pkg.sv
package pga_pkg;

    localparam int PNUM_W = 5;

    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_ALLOC_TX = 2'd1,
        OP_ALLOC_RX = 2'd2,
        OP_RELEASE  = 2'd3
    } op_e;

    typedef struct packed {
        logic              used;
        logic              is_tx;
        logic [PNUM_W-1:0] owner;
    } page_ent_t;

    function automatic logic [PNUM_W-1:0] to_pnum(input int unsigned v);
        return PNUM_W'(v);
    endfunction

endpackage

// File: rtl/pga_pnum_fifo.sv
module pga_pnum_fifo
    import pga_pkg::*;
#(
    parameter int DEPTH = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [PNUM_W-1:0] din,
    input  logic              pop,
    output logic [PNUM_W-1:0] head,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [PNUM_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count;
    logic              full, do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (do_pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // R7: a push into a full FIFO with no pop leaves the contents alone
    p_full_push_dropped_r7: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> ($stable(count) && $stable(head)));

    // R7: a pop from an empty FIFO with no push keeps it empty
    p_empty_pop_stays_r7: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/pga_page_table.sv
module pga_page_table
    import pga_pkg::*;
#(
    parameter int NUM_PAGES  = 18,
    parameter int PAGE_SHIFT = 8,
    parameter int BYTES_W    = 13,
    parameter int CNT_W      = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    input  logic              alloc_is_tx,
    input  logic [BYTES_W-1:0] alloc_bytes,
    input  logic [CNT_W-1:0]  reserve_pages,
    input  logic              rel_a_en,
    input  logic [PNUM_W-1:0] rel_a_pkt,
    input  logic              rel_b_en,
    input  logic [PNUM_W-1:0] rel_b_pkt,
    output logic              alloc_ok,
    output logic [PNUM_W-1:0] alloc_pnum,
    output logic [CNT_W-1:0]  free_cnt
);
    localparam int NEED_W = BYTES_W - PAGE_SHIFT + 1;
    localparam int CMP_W  = ((NEED_W > CNT_W) ? NEED_W : CNT_W) + 2;
    localparam logic [BYTES_W:0] PAGE_MASK = (BYTES_W + 1)'((1 << PAGE_SHIFT) - 1);

    page_ent_t tbl [NUM_PAGES];

    logic [BYTES_W:0]       rounded;
    logic [CMP_W-1:0]       need, free_w, tx_w, hold, taken;
    logic [CNT_W-1:0]       tx_cnt;
    logic [NUM_PAGES-1:0]   pnum_used, grant, rel_hit;

    // page count of the request
    always_comb begin
        rounded = {1'b0, alloc_bytes} + PAGE_MASK;
        if (alloc_bytes == '0) need = CMP_W'(1);
        else                   need = CMP_W'(rounded[BYTES_W:PAGE_SHIFT]);
    end

    // occupancy, transmit share and packet numbers in use
    always_comb begin
        free_cnt  = '0;
        tx_cnt    = '0;
        pnum_used = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (!tbl[i].used) free_cnt = free_cnt + CNT_W'(1);
            if (tbl[i].used && tbl[i].is_tx) tx_cnt = tx_cnt + CNT_W'(1);
            for (int j = 0; j < NUM_PAGES; j++)
                if (tbl[i].used && tbl[i].owner == to_pnum(j)) pnum_used[j] = 1'b1;
        end
    end

    // lowest free packet number
    always_comb begin
        alloc_pnum = '0;
        for (int j = NUM_PAGES - 1; j >= 0; j--)
            if (!pnum_used[j]) alloc_pnum = to_pnum(j);
    end

    // admission against free pages and the transmit hold-back
    always_comb begin
        free_w = CMP_W'(free_cnt);
        tx_w   = CMP_W'(tx_cnt);
        hold   = (CMP_W'(reserve_pages) > tx_w) ? CMP_W'(reserve_pages) - tx_w : '0;
        if (alloc_is_tx) alloc_ok = (need <= free_w);
        else             alloc_ok = ((need + hold) <= free_w);
    end

    // pick the lowest-indexed free pages
    always_comb begin
        taken = '0;
        grant = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (!tbl[i].used && taken < need) begin
                grant[i] = 1'b1;
                taken    = taken + CMP_W'(1);
            end
        end
    end

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        assign rel_hit[g] = tbl[g].used &&
                            ((rel_a_en && tbl[g].owner == rel_a_pkt) ||
                             (rel_b_en && tbl[g].owner == rel_b_pkt));

        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[g] <= '0;
            end else if (rel_hit[g]) begin
                tbl[g].used <= 1'b0;
            end else if (alloc_req && alloc_ok && grant[g]) begin
                tbl[g].used  <= 1'b1;
                tbl[g].is_tx <= alloc_is_tx;
                tbl[g].owner <= alloc_pnum;
            end
        end
    end

    // R2: a granted allocation with no release removes exactly its page count
    p_grant_accounting_r2: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && alloc_ok && !rel_a_en && !rel_b_en)
        |=> (CMP_W'(free_cnt) + $past(need) == CMP_W'($past(free_cnt))));

    // R3: a refused allocation with no release leaves occupancy unchanged
    p_refusal_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && !alloc_ok && !rel_a_en && !rel_b_en) |=> $stable(free_cnt));

    // R8: a release never lowers the free count unless pages are granted
    p_release_monotonic_r8: assert property (@(posedge clk) disable iff (rst)
        ((rel_a_en || rel_b_en) && !alloc_req) |=> (free_cnt >= $past(free_cnt)));

endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
    import pga_pkg::*;
#(
    parameter int NUM_PAGES  = 18,
    parameter int PAGE_BYTES = 256,
    parameter int PAGE_SHIFT = $clog2(PAGE_BYTES),
    parameter int BYTES_W    = $clog2(NUM_PAGES * PAGE_BYTES + 1),
    parameter int CNT_W      = $clog2(NUM_PAGES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [BYTES_W-1:0] cmd_bytes,
    input  logic               pnr_wr,
    input  logic [PNUM_W-1:0]  pnr_din,
    input  logic [CNT_W-1:0]   reserve_pages,
    input  logic               auto_release,
    input  logic               tx_done_valid,
    input  logic [PNUM_W-1:0]  tx_done_pkt,
    input  logic               tx_done_ok,
    input  logic               rx_done_valid,
    input  logic [PNUM_W-1:0]  rx_done_pkt,
    input  logic               rx_pop,
    input  logic               tx_pop,
    output logic [PNUM_W-1:0]  pnr_q,
    output logic               alloc_done,
    output logic               alloc_fail,
    output logic [PNUM_W-1:0]  alloc_pkt,
    output logic [CNT_W-1:0]   free_pages,
    output logic [PNUM_W-1:0]  rx_head,
    output logic               rx_empty,
    output logic [PNUM_W-1:0]  tx_head,
    output logic               tx_empty
);
    localparam int NQ = 2;   // queue 0: receive, queue 1: transmit completion

    op_e               op;
    logic              alloc_req, alloc_is_tx, rel_cmd, auto_rel;
    logic              alloc_ok;
    logic [PNUM_W-1:0] alloc_pnum;
    logic              q_push [NQ];
    logic              q_pop  [NQ];
    logic [PNUM_W-1:0] q_din  [NQ];
    logic [PNUM_W-1:0] q_head [NQ];
    logic              q_empty[NQ];

    assign op          = op_e'(cmd_op);
    assign alloc_req   = cmd_valid && (op == OP_ALLOC_TX || op == OP_ALLOC_RX);
    assign alloc_is_tx = (op == OP_ALLOC_TX);
    assign rel_cmd     = cmd_valid && (op == OP_RELEASE);
    assign auto_rel    = tx_done_valid && tx_done_ok && auto_release;

    pga_page_table #(
        .NUM_PAGES (NUM_PAGES),
        .PAGE_SHIFT(PAGE_SHIFT),
        .BYTES_W   (BYTES_W),
        .CNT_W     (CNT_W)
    ) u_table (
        .clk          (clk),
        .rst          (rst),
        .alloc_req    (alloc_req),
        .alloc_is_tx  (alloc_is_tx),
        .alloc_bytes  (cmd_bytes),
        .reserve_pages(reserve_pages),
        .rel_a_en     (rel_cmd),
        .rel_a_pkt    (pnr_q),
        .rel_b_en     (auto_rel),
        .rel_b_pkt    (tx_done_pkt),
        .alloc_ok     (alloc_ok),
        .alloc_pnum   (alloc_pnum),
        .free_cnt     (free_pages)
    );

    assign q_push[0] = rx_done_valid;
    assign q_din[0]  = rx_done_pkt;
    assign q_pop[0]  = rx_pop;
    assign q_push[1] = tx_done_valid && !auto_rel;
    assign q_din[1]  = tx_done_pkt;
    assign q_pop[1]  = tx_pop;

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        pga_pnum_fifo #(.DEPTH(NUM_PAGES)) u_fifo (
            .clk  (clk),
            .rst  (rst),
            .push (q_push[q]),
            .din  (q_din[q]),
            .pop  (q_pop[q]),
            .head (q_head[q]),
            .empty(q_empty[q])
        );
    end

    assign rx_head  = q_head[0];
    assign rx_empty = q_empty[0];
    assign tx_head  = q_head[1];
    assign tx_empty = q_empty[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            pnr_q      <= '0;
            alloc_done <= 1'b0;
            alloc_fail <= 1'b0;
            alloc_pkt  <= '0;
        end else begin
            if (pnr_wr) pnr_q <= pnr_din;
            if (alloc_req) begin
                alloc_done <= alloc_ok;
                alloc_fail <= !alloc_ok;
                if (alloc_ok) alloc_pkt <= alloc_pnum;
            end
        end
    end

    // R3: success and failure are never reported together
    p_done_fail_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(alloc_done && alloc_fail));

    // R2: a successful allocation without a same-cycle release lowers free pages
    p_done_lowers_free_r2: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && !rel_cmd && !auto_rel) ##1 alloc_done |-> (free_pages < $past(free_pages)));

    // R6: an automatically released completion never reaches the completion queue
    p_auto_release_unqueued_r6: assert property (@(posedge clk) disable iff (rst)
        (auto_rel && !tx_pop) |=> ($stable(tx_empty) && $stable(tx_head)));

    // R9: the packet-number register only moves on a write
    p_pnr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !pnr_wr |=> $stable(pnr_q));

endmodule

// File: tb/pkt_page_alloc_tb.sv
module pkt_page_alloc_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [12:0] cmd_bytes;
    logic        pnr_wr;
    logic [4:0]  pnr_din;
    logic [4:0]  reserve_pages;
    logic        auto_release;
    logic        tx_done_valid;
    logic [4:0]  tx_done_pkt;
    logic        tx_done_ok;
    logic        rx_done_valid;
    logic [4:0]  rx_done_pkt;
    logic        rx_pop, tx_pop;
    logic [4:0]  pnr_q, alloc_pkt, free_pages, rx_head, tx_head;
    logic        alloc_done, alloc_fail, rx_empty, tx_empty;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pkt_page_alloc u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bytes(cmd_bytes), .pnr_wr(pnr_wr), .pnr_din(pnr_din),
        .reserve_pages(reserve_pages), .auto_release(auto_release),
        .tx_done_valid(tx_done_valid), .tx_done_pkt(tx_done_pkt),
        .tx_done_ok(tx_done_ok), .rx_done_valid(rx_done_valid),
        .rx_done_pkt(rx_done_pkt), .rx_pop(rx_pop), .tx_pop(tx_pop),
        .pnr_q(pnr_q), .alloc_done(alloc_done), .alloc_fail(alloc_fail),
        .alloc_pkt(alloc_pkt), .free_pages(free_pages), .rx_head(rx_head),
        .rx_empty(rx_empty), .tx_head(tx_head), .tx_empty(tx_empty)
    );

    // vector: op[31:30] bytes[29:17] done[16] fail[15] pkt[14:10] free[9:5]
    localparam int NVEC = 7;
    localparam logic [31:0] VEC [NVEC] = '{
        {2'd1, 13'd100,  1'b1, 1'b0, 5'd0, 5'd17, 5'd0},
        {2'd1, 13'd256,  1'b1, 1'b0, 5'd1, 5'd16, 5'd0},
        {2'd1, 13'd257,  1'b1, 1'b0, 5'd2, 5'd14, 5'd0},
        {2'd2, 13'd0,    1'b1, 1'b0, 5'd3, 5'd13, 5'd0},
        {2'd1, 13'd4608, 1'b0, 1'b1, 5'd3, 5'd13, 5'd0},
        {2'd2, 13'd3000, 1'b1, 1'b0, 5'd4, 5'd1,  5'd0},
        {2'd1, 13'd300,  1'b0, 1'b1, 5'd4, 5'd1,  5'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        cmd_valid = 0; cmd_op = 0; cmd_bytes = 0; pnr_wr = 0; pnr_din = 0;
        tx_done_valid = 0; tx_done_pkt = 0; tx_done_ok = 0;
        rx_done_valid = 0; rx_done_pkt = 0; rx_pop = 0; tx_pop = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic command(input logic [1:0] op, input int bytes);
        cmd_valid = 1; cmd_op = op; cmd_bytes = 13'(bytes);
        tick();
    endtask

    task automatic release_pkt(input int p);
        pnr_wr = 1; pnr_din = 5'(p);
        tick();
        chk("R9 pnr write", int'(pnr_q), p);
        command(2'd3, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        reserve_pages = 0; auto_release = 0; rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 free", int'(free_pages), 18);
        chk("R1 rx empty", int'(rx_empty), 1);
        chk("R1 tx empty", int'(tx_empty), 1);
        chk("R1 done", int'(alloc_done), 0);
        chk("R1 fail", int'(alloc_fail), 0);
        chk("R1 pnr", int'(pnr_q), 0);

        // R2 / R3 vector walk
        for (int v = 0; v < NVEC; v++) begin
            command(VEC[v][31:30], int'(VEC[v][29:17]));
            chk("R2 R3 done", int'(alloc_done), int'(VEC[v][16]));
            chk("R2 R3 fail", int'(alloc_fail), int'(VEC[v][15]));
            chk("R2 R3 pkt", int'(alloc_pkt), int'(VEC[v][14:10]));
            chk("R2 R3 free", int'(free_pages), int'(VEC[v][9:5]));
        end

        // R4 release packet 4 (12 pages)
        release_pkt(4);
        chk("R4 free after release", int'(free_pages), 13);
        // R3 retry of the earlier refused request now succeeds
        command(2'd1, 300);
        chk("R3 retry done", int'(alloc_done), 1);
        chk("R3 retry pkt", int'(alloc_pkt), 4);
        release_pkt(4);
        chk("R4 free again", int'(free_pages), 13);

        // R5 reserve 8, transmit owns 4 pages, hold 4, free 13
        reserve_pages = 8;
        command(2'd2, 2560);
        chk("R5 rx over hold fail", int'(alloc_fail), 1);
        chk("R5 rx over hold free", int'(free_pages), 13);
        command(2'd2, 2304);
        chk("R5 rx at hold done", int'(alloc_done), 1);
        chk("R5 rx pkt", int'(alloc_pkt), 4);
        chk("R5 rx free", int'(free_pages), 4);
        command(2'd1, 1024);
        chk("R5 tx ignores hold", int'(alloc_done), 1);
        chk("R5 tx pkt", int'(alloc_pkt), 5);
        chk("R5 tx free", int'(free_pages), 0);
        release_pkt(5);
        release_pkt(4);
        chk("R4 free restored", int'(free_pages), 13);
        reserve_pages = 0;

        // R8 allocation plus auto release of packet 2 in one cycle
        auto_release = 1;
        tx_done_valid = 1; tx_done_pkt = 2; tx_done_ok = 1;
        command(2'd1, 3328);
        chk("R8 done", int'(alloc_done), 1);
        chk("R8 pkt", int'(alloc_pkt), 4);
        chk("R8 free", int'(free_pages), 2);
        chk("R6 auto not queued", int'(tx_empty), 1);

        // R8 request judged on old count: 3 pages vs 2 free, release 1
        tx_done_valid = 1; tx_done_pkt = 1; tx_done_ok = 1;
        command(2'd1, 768);
        chk("R8 fail on old count", int'(alloc_fail), 1);
        chk("R8 free after release", int'(free_pages), 3);
        chk("R6 still empty", int'(tx_empty), 1);

        // R6 completions that are queued
        auto_release = 0;
        tx_done_valid = 1; tx_done_pkt = 0; tx_done_ok = 1;
        tick();
        chk("R6 queued no auto", int'(tx_empty), 0);
        chk("R6 head", int'(tx_head), 0);
        chk("R6 pages kept", int'(free_pages), 3);
        auto_release = 1;
        tx_done_valid = 1; tx_done_pkt = 3; tx_done_ok = 0;
        tick();
        chk("R6 failed send kept", int'(free_pages), 3);
        tx_pop = 1; tick();
        chk("R6 second entry", int'(tx_head), 3);
        tx_pop = 1; tick();
        chk("R7 tx drained", int'(tx_empty), 1);
        tx_pop = 1; tick();
        chk("R7 pop empty", int'(tx_empty), 1);

        // R7 receive FIFO fill, overflow, drain in order
        for (int i = 0; i < 18; i++) begin
            rx_done_valid = 1; rx_done_pkt = 5'(i + 3);
            tick();
        end
        rx_done_valid = 1; rx_done_pkt = 5'd31;
        tick();
        for (int i = 0; i < 18; i++) begin
            chk("R7 order", int'(rx_head), i + 3);
            rx_pop = 1; tick();
        end
        chk("R7 overflow dropped", int'(rx_empty), 1);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule